// File: doc/BRIEF.md
# Prescaled Interval Match Timer Channel

A single up/down counter channel for a general-purpose timer. The count advances on a tick from a power-of-two prescaler, or on every clock when the prescaler is off. It runs either across its full width, or from zero up to a programmable interval value and back. Each time the count wraps, the channel emits a one-cycle pulse. The pulse is the overflow event in free-running mode and the interval event in interval mode. Three comparators watch the count and pulse their own event when the count takes their value.

The channel takes its control words as plain levels every clock and has no bus interface. The low four bits of the counter-control word go into a stored control register. Bit 4 of that word acts as a reset command on any cycle it is set. The `cnt_rst_i` strobe has the same effect. Status latching and interrupt masking are left to the surrounding logic, which collects the event pulses.

Top module: `pim_timer`

## Requirements
- R1: Under `rst_ni` low, the count is 0 and all event outputs are low. The stored control resets to "stopped" (low nibble 4'b0001). A counter-control word takes effect one clock after the clock edge that samples it, so the first edge after reset never advances the count.
- R2: With clock-control bit 0 clear and the channel running, the count changes by one step on every clock.
- R3: With clock-control bit 0 set, bits [4:1] give N and the count steps once every 2^(N+1) clocks. The first step comes 2^(N+1) clocks after the divider was last cleared.
- R4: While stored counter-control bit 0 (stop) is set, the count and the prescaler divider both hold. No event fires.
- R5: With counter-control bit 1 clear and bit 2 clear, the count steps up. From 0xFFFF it goes to 0 and `ovf_evt_o` pulses.
- R6: With counter-control bit 1 set, the top value is `interval_i`. An up step from a count at or above the top goes to 0 and pulses `intv_evt_o`, not `ovf_evt_o`.
- R7: With counter-control bit 2 set, the count steps down. A step from 0 reloads the top value: `interval_i` with `intv_evt_o` in interval mode, 0xFFFF with `ovf_evt_o` otherwise.
- R8: With counter-control bit 3 set, `match_evt_o[i]` pulses in the same cycle that `cnt_o` first shows a step result equal to `match_i[i]`. This includes a result reached by a wrap or a reload.
- R9: A match value above the current top value never fires. No match fires while counter-control bit 3 is clear.
- R10: `cnt_rst_i` high, or counter-control bit 4 high, clears the count and the divider at the next edge. No event fires for that edge. Bit 4 is not part of the stored control.
- R11: Every event is a single-cycle pulse tied to one step. The overflow and interval events are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_ctrl_i | input | PSC_SEL_W+1 | Bit 0 enables the prescaler, upper bits give N |
| cnt_ctrl_i | input | 5 | Stop, interval mode, decrement, match enable, reset command (bits 0..4) |
| cnt_rst_i | input | 1 | One-cycle counter reset strobe |
| interval_i | input | CNT_W | Top value in interval mode |
| match_i | input | NUM_MATCH x CNT_W | Match comparator values |
| cnt_o | output | CNT_W | Current count |
| intv_evt_o | output | 1 | Interval wrap pulse |
| ovf_evt_o | output | 1 | Full-range wrap pulse |
| match_evt_o | output | NUM_MATCH | Per-comparator match pulses |

## Verification
The properties assume that every input is at a known level from the first clock after reset. They also assume that the interval and match values that bear on a step are the ones sampled at that step's edge. The checks compare each output against values sampled one cycle earlier, so no property has to track a value that changes in the middle of a step. The bench changes inputs only just after a falling edge, and it holds every input at a defined value from time zero. Interval and match values change only between phases, so each phase runs against steady settings.

// File: rtl/pim_timer_pkg.sv
package pim_timer_pkg;
  localparam int unsigned CC_STOP = 0;
  localparam int unsigned CC_INTV = 1;
  localparam int unsigned CC_DEC  = 2;
  localparam int unsigned CC_MEN  = 3;
  localparam int unsigned CC_RST  = 4;

  typedef struct packed {
    logic match_en;
    logic dec;
    logic intv_mode;
    logic stop;
  } cnt_ctrl_t;

  localparam cnt_ctrl_t CNT_CTRL_RST = '{match_en: 1'b0, dec: 1'b0, intv_mode: 1'b0, stop: 1'b1};
endpackage

// File: rtl/pim_prescaler.sv
module pim_prescaler #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << SEL_W) + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  // 2^(N+1) - 1
  assign limit  = (DIV_W'(2) << sel_i) - DIV_W'(1);
  assign tick_o = !en_i || (div_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (clr_i) begin
      div_q <= '0;
    end else if (!hold_i) begin
      if (!en_i || tick_o) div_q <= '0;
      else                 div_q <= div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pim_count_core.sv
module pim_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             dec_i,
  input  logic             intv_mode_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] nxt_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             intv_evt_o,
  output logic             ovf_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  // up: anything at or above top folds to zero
  assign wrap  = dec_i ? (cnt_q == '0) : (cnt_q >= top_i);
  assign nxt_o = wrap  ? (dec_i ? top_i : '0)
                       : (dec_i ? cnt_q - CNT_W'(1) : cnt_q + CNT_W'(1));
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      intv_evt_o <= 1'b0;
      ovf_evt_o  <= 1'b0;
    end else if (clr_i) begin
      cnt_q      <= '0;
      intv_evt_o <= 1'b0;
      ovf_evt_o  <= 1'b0;
    end else begin
      if (step_i) cnt_q <= nxt_o;
      intv_evt_o <= step_i && wrap &&  intv_mode_i;
      ovf_evt_o  <= step_i && wrap && !intv_mode_i;
    end
  end
endmodule

// File: rtl/pim_match.sv
module pim_match #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             evt_o
);
  logic hit;

  assign hit = en_i && step_i && (nxt_i == val_i) && (val_i <= top_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     evt_o <= 1'b0;
    else if (clr_i)  evt_o <= 1'b0;
    else             evt_o <= hit;
  end
endmodule

// File: rtl/pim_timer.sv
module pim_timer
  import pim_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned NUM_MATCH = 3,
  parameter int unsigned PSC_SEL_W = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [PSC_SEL_W:0]                clk_ctrl_i,
  input  logic [4:0]                        cnt_ctrl_i,
  input  logic                              cnt_rst_i,
  input  logic [CNT_W-1:0]                  interval_i,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0]   match_i,
  output logic [CNT_W-1:0]                  cnt_o,
  output logic                              intv_evt_o,
  output logic                              ovf_evt_o,
  output logic [NUM_MATCH-1:0]              match_evt_o
);
  cnt_ctrl_t        ctrl_q;
  logic             rst_cmd;
  logic             tick;
  logic             step;
  logic             stop_q, dec_q, intv_q, men_q;
  logic [CNT_W-1:0] top_val;
  logic [CNT_W-1:0] nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CNT_CTRL_RST;
    else         ctrl_q <= cnt_ctrl_t'(cnt_ctrl_i[CC_MEN:CC_STOP]);
  end

  assign stop_q  = ctrl_q.stop;
  assign dec_q   = ctrl_q.dec;
  assign intv_q  = ctrl_q.intv_mode;
  assign men_q   = ctrl_q.match_en;
  assign rst_cmd = cnt_rst_i || cnt_ctrl_i[CC_RST];
  assign top_val = intv_q ? interval_i : '1;
  assign step    = tick && !stop_q && !rst_cmd;

  pim_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rst_cmd),
    .hold_i (stop_q),
    .en_i   (clk_ctrl_i[0]),
    .sel_i  (clk_ctrl_i[PSC_SEL_W:1]),
    .tick_o (tick)
  );

  pim_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (rst_cmd),
    .step_i      (step),
    .dec_i       (dec_q),
    .intv_mode_i (intv_q),
    .top_i       (top_val),
    .nxt_o       (nxt),
    .cnt_o       (cnt_o),
    .intv_evt_o  (intv_evt_o),
    .ovf_evt_o   (ovf_evt_o)
  );

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    pim_match #(.CNT_W(CNT_W)) u_match (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (rst_cmd),
      .step_i (step),
      .en_i   (men_q),
      .nxt_i  (nxt),
      .top_i  (top_val),
      .val_i  (match_i[i]),
      .evt_o  (match_evt_o[i])
    );
  end
endmodule

// File: rtl/pim_timer_chk.sv
module pim_timer_chk #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned NUM_MATCH = 3
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            rst_cmd_i,
  input logic                            stop_q_i,
  input logic                            dec_q_i,
  input logic                            intv_q_i,
  input logic                            men_q_i,
  input logic [CNT_W-1:0]                interval_i,
  input logic [NUM_MATCH-1:0][CNT_W-1:0] match_i,
  input logic [CNT_W-1:0]                cnt_i,
  input logic                            intv_evt_i,
  input logic                            ovf_evt_i,
  input logic [NUM_MATCH-1:0]            match_evt_i
);
  AST_RST_CMD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_cmd_i) |-> (cnt_i == '0 && !intv_evt_i && !ovf_evt_i && match_evt_i == '0)); // R10
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stop_q_i) && !$past(rst_cmd_i)) |-> (cnt_i == $past(cnt_i))); // R4
  AST_EVT_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intv_evt_i || ovf_evt_i || (|match_evt_i)) |-> !$past(stop_q_i)); // R4
  AST_UP_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((intv_evt_i || ovf_evt_i) && !$past(dec_q_i)) |-> (cnt_i == '0)); // R5
  AST_INTV_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intv_evt_i |-> $past(intv_q_i)); // R6
  AST_OVF_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |-> !$past(intv_q_i)); // R5
  AST_DOWN_INTV_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intv_evt_i && $past(dec_q_i)) |-> (cnt_i == $past(interval_i))); // R7
  AST_DOWN_OVF_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_evt_i && $past(dec_q_i)) |-> (&cnt_i)); // R7
  AST_WRAP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({intv_evt_i, ovf_evt_i})); // R11

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_chk
    AST_MATCH_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_evt_i[i] |-> (cnt_i == $past(match_i[i]) && $past(men_q_i))); // R8
    AST_MATCH_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_evt_i[i] |-> (!$past(intv_q_i) || $past(match_i[i]) <= $past(interval_i))); // R9
  end
endmodule

bind pim_timer pim_timer_chk #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_cmd_i   (rst_cmd),
  .stop_q_i    (stop_q),
  .dec_q_i     (dec_q),
  .intv_q_i    (intv_q),
  .men_q_i     (men_q),
  .interval_i  (interval_i),
  .match_i     (match_i),
  .cnt_i       (cnt_o),
  .intv_evt_i  (intv_evt_o),
  .ovf_evt_i   (ovf_evt_o),
  .match_evt_i (match_evt_o)
);

// File: tb/pim_timer_test.sv
`timescale 1ns/1ps
module pim_timer_test;
  localparam int CNT_W = 16;
  localparam int NM    = 3;
  localparam int PSW   = 4;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [PSW:0]             clk_ctrl = '0;
  logic [4:0]               cnt_ctrl = '0;
  logic                     cnt_rst = 1'b0;
  logic [CNT_W-1:0]         interval = '0;
  logic [NM-1:0][CNT_W-1:0] match = '0;
  logic [CNT_W-1:0]         cnt;
  logic                     intv_evt, ovf_evt;
  logic [NM-1:0]            match_evt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pim_timer #(.CNT_W(CNT_W), .NUM_MATCH(NM), .PSC_SEL_W(PSW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_ctrl_i(clk_ctrl), .cnt_ctrl_i(cnt_ctrl),
    .cnt_rst_i(cnt_rst), .interval_i(interval), .match_i(match),
    .cnt_o(cnt), .intv_evt_o(intv_evt), .ovf_evt_o(ovf_evt), .match_evt_o(match_evt)
  );

  typedef struct {
    logic [CNT_W-1:0] cnt;
    logic             intv;
    logic             ovf;
    logic [NM-1:0]    m;
    string            tag;
  } exp_t;

  exp_t sb[$];

  // reference state, built from the requirements
  logic [3:0]       m_ctrl = 4'b0001;
  int               m_psc  = 0;
  logic [CNT_W-1:0] m_cnt  = '0;

  task automatic cyc(input string tag);
    exp_t e;
    logic [CNT_W-1:0] top;
    logic tick, wrap;
    e.intv = 1'b0; e.ovf = 1'b0; e.m = '0; e.tag = tag;
    if (cnt_rst || cnt_ctrl[4]) begin
      m_cnt = '0;
      m_psc = 0;
    end else if (!m_ctrl[0]) begin
      tick = !clk_ctrl[0] || (m_psc == ((1 << (int'(clk_ctrl[PSW:1]) + 1)) - 1));
      if (clk_ctrl[0] && !tick) m_psc = m_psc + 1;
      else                      m_psc = 0;
      if (tick) begin
        top = m_ctrl[1] ? interval : 16'hFFFF;
        if (!m_ctrl[2]) begin
          wrap  = (m_cnt >= top);
          m_cnt = wrap ? 16'h0 : m_cnt + 16'h1;
        end else begin
          wrap  = (m_cnt == 16'h0);
          m_cnt = wrap ? top : m_cnt - 16'h1;
        end
        e.intv = wrap &&  m_ctrl[1];
        e.ovf  = wrap && !m_ctrl[1];
        for (int i = 0; i < NM; i++)
          e.m[i] = m_ctrl[3] && (match[i] <= top) && (m_cnt == match[i]);
      end
    end
    m_ctrl = cnt_ctrl[3:0];
    e.cnt  = m_cnt;
    sb.push_back(e);
    @(negedge clk);
    #1;
  endtask

  // monitor: R11 is covered by comparing every event bit on every cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (cnt !== e.cnt || intv_evt !== e.intv || ovf_evt !== e.ovf || match_evt !== e.m) begin
        errors++;
        $display("FAIL %s t=%0t: cnt=%h intv=%b ovf=%b m=%b, expected cnt=%h intv=%b ovf=%b m=%b",
                 e.tag, $time, cnt, intv_evt, ovf_evt, match_evt, e.cnt, e.intv, e.ovf, e.m);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    #12;
    // R1: values held under reset
    checks++;
    if (cnt !== '0 || intv_evt !== 1'b0 || ovf_evt !== 1'b0 || match_evt !== '0) begin
      errors++;
      $display("FAIL R1 reset: cnt=%h ev=%b%b%b, expected 0000 000", cnt, intv_evt, ovf_evt, match_evt);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: control says run, but the stored control is still "stopped" for one edge
    cyc("R1");
    repeat (10) cyc("R2");
    repeat (65540) cyc("R5");
    cnt_ctrl = 5'b00001;
    repeat (5) cyc("R4");
    cnt_ctrl = 5'b10001;
    cyc("R10");
    cnt_ctrl = 5'b00001;
    cyc("R10");

    // interval up, one match above the top
    interval = 16'd5;
    match[0] = 16'd2; match[1] = 16'd5; match[2] = 16'd7;
    cnt_ctrl = 5'b11010;
    cyc("R6");
    cnt_ctrl = 5'b01010;
    repeat (14) cyc("R6");
    // matches reached through the wrap
    match[0] = 16'd0; match[1] = 16'd3; match[2] = 16'd5;
    repeat (12) cyc("R8");
    // above-top with enable on, then enable off
    match[0] = 16'd6; match[1] = 16'd9; match[2] = 16'd4;
    repeat (8) cyc("R9");
    cnt_ctrl = 5'b00010;
    match[0] = 16'd1; match[1] = 16'd2; match[2] = 16'd3;
    repeat (8) cyc("R9");
    // count above a lowered interval folds to zero
    cnt_ctrl = 5'b01010;
    interval = 16'd20;
    repeat (18) cyc("R6");
    interval = 16'd4;
    repeat (6) cyc("R6");

    // down counting, interval then free
    interval = 16'd5;
    match[0] = 16'd1; match[1] = 16'd5; match[2] = 16'd8;
    cnt_ctrl = 5'b11110;
    cyc("R7");
    cnt_ctrl = 5'b01110;
    repeat (14) cyc("R7");
    cnt_ctrl = 5'b10100;
    cyc("R7");
    cnt_ctrl = 5'b00100;
    repeat (4) cyc("R7");

    // prescaler N=0 then N=2
    clk_ctrl = {4'd0, 1'b1};
    cnt_ctrl = 5'b10000;
    cyc("R3");
    cnt_ctrl = 5'b00000;
    repeat (12) cyc("R3");
    clk_ctrl = {4'd2, 1'b1};
    cnt_ctrl = 5'b10000;
    cyc("R3");
    cnt_ctrl = 5'b00000;
    repeat (40) cyc("R3");
    // stop in mid-division: divider holds
    repeat (3) cyc("R4");
    cnt_ctrl = 5'b00001;
    repeat (6) cyc("R4");
    cnt_ctrl = 5'b00000;
    repeat (12) cyc("R4");
    // reset strobe clears count and divider
    cnt_rst = 1'b1;
    cyc("R10");
    cnt_rst = 1'b0;
    repeat (20) cyc("R10");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule